// File: doc/BRIEF.md
# H-Bridge Gate Command Sequencer

This block turns a two-bit drive request into on/off commands for the four switches of a full bridge. Each output leg has a high-side and a low-side switch. The request selects one of four states: coast, forward, reverse or brake. Each leg enforces a break-before-make gap whenever it hands conduction from one of its switches to the other. This holds even when the handover is spread across a forced-off interval requested by protection logic.

A sleep sequencer sits in front of the decoder. If the request stays at coast long enough, the bridge goes to sleep. Waking it needs a qualified non-zero request followed by a turn-on delay, and the switches stay off throughout. Coming out of reset, or regaining power-good, while the request is coast puts the block straight into sleep. All times are parameters counted in clock cycles. The two request bits pass through a synchroniser, so a PWM waveform on them reaches the gates with a fixed latency.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While operational, the request {in2,in1} maps to gates as follows. 00 (coast) gives all four off. 01 (forward) gives leg-1 high and leg-2 low. 10 (reverse) gives leg-1 low and leg-2 high. 11 (brake) gives both low switches on. Gate vectors use index 0 for leg 1 and index 1 for leg 2.
- R2: The high-side and low-side gates of one leg are never on in the same cycle.
- R3: When a leg's next conducting switch is the opposite one from the last, both of its gates stay off for exactly DEAD_CYC cycles before the new one turns on. A return to the same switch incurs no gap.
- R4: While operational, after SLEEP_CYC consecutive synchronised coast samples, `asleep` rises and all gates are off.
- R5: Any non-coast sample before the idle count expires restarts the idle count.
- R6: Leaving reset, or pwrGood rising, with the request at coast raises `asleep` within a few cycles, with no idle wait.
- R7: From sleep, a wake needs QUAL_CYC consecutive non-coast samples. A shorter burst leaves `asleep` high and the gates off.
- R8: After qualification `asleep` falls, and the gates stay off for a further TON_CYC cycles before the decoded state is driven.
- R9: forceOff high turns every gate off on the next clock edge. When it drops, drive resumes under the R3 gap rule.
- R10: pwrGood low turns every gate off. When it returns with a non-coast request, the R8 turn-on delay applies again.
- R11: While operational, a change of request reaches the gates SYNC_STAGES+1 clock edges after it is first sampled, whatever the switching rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| in1 | input | 1 | Drive request bit 1 (asynchronous) |
| in2 | input | 1 | Drive request bit 2 (asynchronous) |
| pwrGood | input | 1 | Supply good; low disables the bridge |
| forceOff | input | 1 | Protection override, all gates off |
| hiGate | output | 2 | High-side gate enables, [0]=leg 1, [1]=leg 2 |
| loGate | output | 2 | Low-side gate enables, [0]=leg 1, [1]=leg 2 |
| asleep | output | 1 | Bridge in sleep or wake qualification |

## Verification
A sequencer stuck in the wrong phase shows at the ports as `asleep` or the gates disagreeing with the request. The idle or wake counters stop at the wrong count, so `asleep` moves tens of cycles early or late, and the bench brackets each boundary on both sides. A leg holding the wrong last-conducting side shows on the very next reversal, as a gap that is missing or too short. The bench measures that gap cycle by cycle on leg 1.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_HIGH = 2'b01,
    LEG_LOW  = 2'b10
  } legCmd_t;

  typedef struct packed {
    logic              driveOk;
    legCmd_t [1:0]     leg;
  } bridgeStrobe_t;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SLEEP,
    ST_QUAL,
    ST_TURNON,
    ST_ACTIVE
  } seqState_t;

  // A leg goes high when its own bit alone is set, low when the other bit is set.
  function automatic legCmd_t decodeLeg(input logic ownBit, input logic otherBit);
    if (!ownBit && !otherBit) return LEG_OFF;
    if (ownBit && !otherBit)  return LEG_HIGH;
    return LEG_LOW;
  endfunction

endpackage

// File: rtl/hbr_seq.sv
module hbr_seq
  import hbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 625,
  parameter int TON_CYC     = 6250,
  parameter int SLEEP_CYC   = 125000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    inRaw,
  input  logic          pwrGood,
  input  logic          forceOff,
  output bridgeStrobe_t strobe,
  output logic          asleep
);

  localparam int MAXA  = (QUAL_CYC > TON_CYC) ? QUAL_CYC : TON_CYC;
  localparam int MAXC  = (MAXA > SLEEP_CYC) ? MAXA : SLEEP_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] QUAL_LAST  = CNT_W'(QUAL_CYC - 1);
  localparam logic [CNT_W-1:0] TON_LAST   = CNT_W'(TON_CYC - 1);
  localparam logic [CNT_W-1:0] SLEEP_LAST = CNT_W'(SLEEP_CYC - 1);

  logic [1:0]             syncPipe [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] primed;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) begin
            syncPipe[g] <= 2'b00;
            primed[g]   <= 1'b0;
          end else begin
            syncPipe[g] <= inRaw;
            primed[g]   <= 1'b1;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) begin
            syncPipe[g] <= 2'b00;
            primed[g]   <= 1'b0;
          end else begin
            syncPipe[g] <= syncPipe[g-1];
            primed[g]   <= primed[g-1];
          end
        end
      end
    end
  endgenerate

  logic [1:0]       inS;
  logic             ready;
  logic             inIdle;
  seqState_t        state;
  logic [CNT_W-1:0] cnt;

  assign inS    = syncPipe[SYNC_STAGES-1];
  assign ready  = primed[SYNC_STAGES-1];
  assign inIdle = (inS == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else if (!pwrGood) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (ready) begin
            cnt   <= '0;
            state <= inIdle ? ST_SLEEP : ST_TURNON;
          end
        end
        ST_SLEEP: begin
          if (!inIdle) begin
            state <= ST_QUAL;
            cnt   <= CNT_W'(1);
          end
        end
        ST_QUAL: begin
          if (inIdle) begin
            state <= ST_SLEEP;
            cnt   <= '0;
          end else if (cnt == QUAL_LAST) begin
            state <= ST_TURNON;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TURNON: begin
          if (cnt == TON_LAST) begin
            state <= ST_ACTIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (!inIdle) begin
            cnt <= '0;
          end else if (cnt == SLEEP_LAST) begin
            state <= ST_SLEEP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_OFF;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strobe.driveOk = (state == ST_ACTIVE) && !forceOff;
    strobe.leg[0]  = decodeLeg(inS[0], inS[1]);
    strobe.leg[1]  = decodeLeg(inS[1], inS[0]);
    asleep         = (state == ST_SLEEP) || (state == ST_QUAL);
  end

  // R5
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !inIdle && pwrGood) |=> (state != ST_SLEEP));

  // R6
  direct_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && ready && pwrGood && inIdle) |=> asleep);

  // R7
  wake_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TURNON && $past(state == ST_QUAL)) |-> !$past(inIdle));

  // R10
  pwr_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> !strobe.driveOk);

endmodule

// File: rtl/hbr_leg.sv
module hbr_leg
  import hbr_pkg::*;
#(
  parameter int DEAD_CYC = 31
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    driveOk,
  input  legCmd_t cmd,
  output logic    hiOn,
  output logic    loOn
);

  localparam int GW = $clog2(DEAD_CYC + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(DEAD_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(DEAD_CYC - 1);

  legCmd_t       want;
  logic          lastHigh;
  logic [GW-1:0] gap;

  assign want = driveOk ? cmd : LEG_OFF;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiOn     <= 1'b0;
      loOn     <= 1'b0;
      lastHigh <= 1'b0;
      gap      <= GAP_FULL;
    end else begin
      unique case (want)
        LEG_HIGH: begin
          if (loOn) begin
            loOn     <= 1'b0;
            lastHigh <= 1'b0;
            gap      <= '0;
          end else if (!hiOn) begin
            if (lastHigh || gap >= GAP_LAST) hiOn <= 1'b1;
            else                             gap  <= gap + 1'b1;
          end
        end
        LEG_LOW: begin
          if (hiOn) begin
            hiOn     <= 1'b0;
            lastHigh <= 1'b1;
            gap      <= '0;
          end else if (!loOn) begin
            if (!lastHigh || gap >= GAP_LAST) loOn <= 1'b1;
            else                              gap  <= gap + 1'b1;
          end
        end
        default: begin
          if (hiOn || loOn) begin
            hiOn     <= 1'b0;
            loOn     <= 1'b0;
            lastHigh <= hiOn;
            gap      <= '0;
          end else if (gap < GAP_FULL) begin
            gap <= gap + 1'b1;
          end
        end
      endcase
    end
  end

  // Independent observer of the gate pins for the gap rule.
  logic          obsHigh;
  logic [GW-1:0] obsRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obsHigh <= 1'b0;
      obsRun  <= GAP_FULL;
    end else if (hiOn) begin
      obsHigh <= 1'b1;
      obsRun  <= '0;
    end else if (loOn) begin
      obsHigh <= 1'b0;
      obsRun  <= '0;
    end else if (obsRun < GAP_FULL) begin
      obsRun <= obsRun + 1'b1;
    end
  end

  // R2
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hiOn && loOn));

  // R3
  dead_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(loOn) && obsHigh) |-> (obsRun >= GAP_FULL));

  // R3
  dead_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hiOn) && !obsHigh && $past(loOn) == 1'b0 && obsRun != GAP_FULL)
      |-> (obsRun >= GAP_FULL));

  // R9
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveOk |=> (!hiOn && !loOn));

endmodule

// File: rtl/hbr_bridge.sv
module hbr_bridge
  import hbr_pkg::*;
#(
  parameter int DEAD_CYC = 31,
  parameter int N_LEGS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobe_t     strobe,
  output logic [N_LEGS-1:0] hiGate,
  output logic [N_LEGS-1:0] loGate
);

  generate
    for (genvar g = 0; g < N_LEGS; g++) begin : gLeg
      hbr_leg #(.DEAD_CYC(DEAD_CYC)) uLeg (
        .clk     (clk),
        .rstN    (rstN),
        .driveOk (strobe.driveOk),
        .cmd     (strobe.leg[g]),
        .hiOn    (hiGate[g]),
        .loOn    (loGate[g])
      );
    end
  endgenerate

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 625,
  parameter int TON_CYC     = 6250,
  parameter int SLEEP_CYC   = 125000,
  parameter int DEAD_CYC    = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       in1,
  input  logic       in2,
  input  logic       pwrGood,
  input  logic       forceOff,
  output logic [1:0] hiGate,
  output logic [1:0] loGate,
  output logic       asleep
);

  bridgeStrobe_t strobe;

  hbr_seq #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYC    (QUAL_CYC),
    .TON_CYC     (TON_CYC),
    .SLEEP_CYC   (SLEEP_CYC)
  ) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .inRaw    ({in2, in1}),
    .pwrGood  (pwrGood),
    .forceOff (forceOff),
    .strobe   (strobe),
    .asleep   (asleep)
  );

  hbr_bridge #(
    .DEAD_CYC (DEAD_CYC),
    .N_LEGS   (2)
  ) uBridge (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .hiGate (hiGate),
    .loGate (loGate)
  );

endmodule

// File: tb/hbridge_gate_ctrl_test.sv
module hbridge_gate_ctrl_test;

  localparam int SYNC  = 2;
  localparam int QUAL  = 20;
  localparam int TON   = 50;
  localparam int SLP   = 200;
  localparam int DEAD  = 8;

  localparam logic [3:0] G_COAST = 4'b0000;
  localparam logic [3:0] G_FWD   = 4'b0110;  // {hi2,hi1,lo2,lo1}
  localparam logic [3:0] G_REV   = 4'b1001;
  localparam logic [3:0] G_BRAKE = 4'b0011;

  logic clk = 1'b0;
  logic rstN, in1, in2, pwrGood, forceOff;
  logic [1:0] hiGate, loGate;
  logic asleep;
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hbridge_gate_ctrl #(
    .SYNC_STAGES(SYNC), .QUAL_CYC(QUAL), .TON_CYC(TON),
    .SLEEP_CYC(SLP), .DEAD_CYC(DEAD)
  ) uut (
    .clk(clk), .rstN(rstN), .in1(in1), .in2(in2), .pwrGood(pwrGood),
    .forceOff(forceOff), .hiGate(hiGate), .loGate(loGate), .asleep(asleep)
  );

  // Leg-1 gap monitor: off cycles between high-side release and low-side turn-on.
  bit lastHi1 = 0;
  int offRun1 = 0;
  int measGap = -1;
  always @(negedge clk) begin
    if (hiGate[0]) begin
      lastHi1 = 1; offRun1 = 0;
    end else if (loGate[0]) begin
      if (lastHi1) measGap = offRun1;
      lastHi1 = 0; offRun1 = 0;
    end else begin
      offRun1++;
    end
  end

  function automatic logic [3:0] gates();
    return {hiGate[1], hiGate[0], loGate[1], loGate[0]};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setIn(input logic [1:0] code);
    {in2, in1} = code;
  endtask

  task automatic doReset(input logic [1:0] code);
    rstN = 1'b0; pwrGood = 1'b1; forceOff = 1'b0; setIn(code);
    cyc(3);
    chk("R6", "gates in reset", 32'(gates()), 32'(G_COAST));
    rstN = 1'b1;
  endtask

  // Wake from sleep with forward held; returns operational.
  task automatic wakeForward();
    setIn(2'b01);
    cyc(SYNC + QUAL + TON + 10);
  endtask

  task automatic testResetSleep();
    doReset(2'b00);
    cyc(SYNC + 3);
    chk("R6", "asleep after reset", 32'(asleep), 1);
    chk("R6", "gates after reset", 32'(gates()), 32'(G_COAST));
  endtask

  task automatic testShortWake();
    setIn(2'b01);
    cyc(QUAL - 10);
    setIn(2'b00);
    cyc(10);
    chk("R7", "asleep after short burst", 32'(asleep), 1);
    chk("R7", "gates after short burst", 32'(gates()), 32'(G_COAST));
  endtask

  task automatic testWake();
    setIn(2'b01);
    cyc(QUAL - 5);
    chk("R7", "asleep mid qualification", 32'(asleep), 1);
    cyc(15);
    chk("R8", "asleep cleared after qual", 32'(asleep), 0);
    chk("R8", "gates held off in turn-on", 32'(gates()), 32'(G_COAST));
    cyc(TON - 20);
    chk("R8", "gates still off late turn-on", 32'(gates()), 32'(G_COAST));
    cyc(30);
    chk("R1", "forward gates", 32'(gates()), 32'(G_FWD));
  endtask

  task automatic testTable();
    measGap = -1;
    setIn(2'b10); cyc(20);
    chk("R1", "reverse gates", 32'(gates()), 32'(G_REV));
    chk("R3", "forward->reverse gap", 32'(measGap), 32'(DEAD));
    setIn(2'b11); cyc(20);
    chk("R1", "brake gates", 32'(gates()), 32'(G_BRAKE));
    setIn(2'b00); cyc(20);
    chk("R1", "coast gates", 32'(gates()), 32'(G_COAST));
    chk("R4", "awake during short coast", 32'(asleep), 0);
  endtask

  task automatic testLatencyPwm();
    setIn(2'b01);
    cyc(SYNC);
    chk("R11", "hi1 before latency", 32'(hiGate[0]), 0);
    cyc(1);
    chk("R11", "hi1 at latency", 32'(hiGate[0]), 1);
    for (int k = 0; k < 4; k++) begin
      setIn(2'b11); cyc(30);
      chk("R11", "pwm brake phase", 32'(gates()), 32'(G_BRAKE));
      setIn(2'b01); cyc(30);
      chk("R11", "pwm drive phase", 32'(gates()), 32'(G_FWD));
    end
  endtask

  task automatic testIdle();
    setIn(2'b00); cyc(150);
    setIn(2'b01); cyc(5);
    setIn(2'b00); cyc(150);
    chk("R5", "idle count restarted", 32'(asleep), 0);
    cyc(SLP - 150 - 10);
    chk("R4", "awake just before expiry", 32'(asleep), 0);
    cyc(20);
    chk("R4", "asleep after idle time", 32'(asleep), 1);
    chk("R4", "gates off asleep", 32'(gates()), 32'(G_COAST));
  endtask

  task automatic testForce();
    wakeForward();
    chk("R9", "forward before force", 32'(gates()), 32'(G_FWD));
    forceOff = 1'b1; cyc(1);
    chk("R9", "gates off under force", 32'(gates()), 32'(G_COAST));
    forceOff = 1'b0; cyc(1);
    chk("R3", "same side returns at once", 32'(hiGate[0]), 1);
    cyc(5);
    measGap = -1;
    forceOff = 1'b1; cyc(1);
    setIn(2'b10); cyc(3);
    forceOff = 1'b0; cyc(20);
    chk("R9", "gap spans forced interval", 32'(measGap), 32'(DEAD));
    chk("R9", "reverse after release", 32'(gates()), 32'(G_REV));
  endtask

  task automatic testPower();
    pwrGood = 1'b0; cyc(3);
    chk("R10", "gates off on power loss", 32'(gates()), 32'(G_COAST));
    setIn(2'b00); cyc(5);
    pwrGood = 1'b1; cyc(4);
    chk("R6", "asleep on power return idle", 32'(asleep), 1);
    setIn(2'b01); cyc(5);
    pwrGood = 1'b0; cyc(5);
    pwrGood = 1'b1; cyc(20);
    chk("R10", "turn-on delay after power", 32'(gates()), 32'(G_COAST));
    chk("R10", "awake in turn-on", 32'(asleep), 0);
    cyc(TON);
    chk("R10", "drive after turn-on", 32'(gates()), 32'(G_FWD));
  endtask

  initial begin
    rstN = 1'b0; pwrGood = 1'b1; forceOff = 1'b0; in1 = 1'b0; in2 = 1'b0;
    testResetSleep();
    testShortWake();
    testWake();
    testTable();
    testLatencyPwm();
    testIdle();
    testForce();
    testPower();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule